// File: doc/BRIEF.md
# Predicated Vector Integer-to-Float Converter

This block takes a vector of signed two's-complement integers and turns each selected lane into an IEEE-754 binary floating-point number. A 3-bit type select picks one of seven pairings of integer width (16, 32 or 64 bits) and float format (half, single or double). The lane width is the larger of the two widths. A narrower integer is read from the low bits of its lane, and a narrower float is written to the low bits of its lane with zeros above it.

A byte-granular predicate chooses which lanes take the converted value. Every other lane passes the matching bits of an old destination vector through to the output. A 2-bit rounding mode applies to every lane. The merged vector and an inexact flag appear one registered cycle after the input strobe. The inexact flag is the OR of the inexact conditions of all active lanes.

Top module: `vec_i2f_merge`

## Requirements
- R1: `conv_sel` sets the pairing and the lane width. 0 is int16 to half in 16-bit lanes. 1 is int32 to half and 2 is int32 to single, both in 32-bit lanes. 3 is int32 to double, 4 is int64 to half, 5 is int64 to single and 6 is int64 to double, all in 64-bit lanes. Lane k occupies bits [k*W+W-1 : k*W].
- R2: A lane is active when the `pred` bit of its lowest byte (bit k*W/8) is 1. The other `pred` bits of that lane have no effect on the output.
- R3: Every inactive lane outputs the matching bits of `old_vec`. `conv_sel` = 7 makes every lane inactive.
- R4: When the integer is narrower than the lane, only the low integer-width bits of the lane are converted, as a signed value. The upper source bits of the lane are ignored.
- R5: When the float is narrower than the lane, the float fills the low bits of the lane and the bits above it are zero.
- R6: `rnd_mode` selects the rounding of inexact results. 00 is nearest with ties to even, 01 is toward +infinity, 10 is toward -infinity and 11 is toward zero.
- R7: An integer zero converts to +0.0 (all bits zero) and is exact.
- R8: A magnitude that is too large for half precision gives the signed infinity (exponent field all ones, fraction zero). It gives the largest finite value of that sign (0x7BFF magnitude) instead when the rounding mode points away from that infinity. Either result is inexact.
- R9: `out_inexact` is the OR of the inexact conditions of the active lanes only. It is 0 when no lane is active.
- R10: A strobe on `in_valid` shows up as `out_valid`, `out_vec` and `out_inexact` on the next cycle. Without a strobe, `out_valid` is 0 and the outputs hold their last values.
- R11: Reset is synchronous and active-low. It clears `out_valid`, `out_vec` and `out_inexact` to 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| in_valid | input | 1 | Input strobe; the inputs are sampled while it is high |
| src_vec | input | VEC_W | Integer source lanes |
| old_vec | input | VEC_W | Destination contents, kept in inactive lanes |
| pred | input | VEC_W/8 | One predicate bit per byte |
| conv_sel | input | 3 | Conversion pairing select |
| rnd_mode | input | 2 | Rounding mode |
| out_valid | output | 1 | Result strobe, one cycle after `in_valid` |
| out_vec | output | VEC_W | Merged result vector |
| out_inexact | output | 1 | OR of the inexact conditions of active lanes |

## Verification
Each directed pattern separates one behaviour from its neighbours:
- Values that fit exactly are compared against values that need rounding.
- Ties and near-ties at 2^24+1 and 2^24+3 are run under all four rounding modes, so the modes can be told apart.
- The most negative and most positive 64-bit integers probe the magnitude path.
- Source lanes carry junk in their upper bits, which shows whether narrow sources are read correctly.
- Large half-precision inputs of both signs, under each mode, separate the infinity result from the largest finite result.
- Predicates with only non-leading bits set, and predicates that mask off the only inexact lane, show lane gating and flag gating.

A long run of random type selects, modes, predicates and value magnitudes, with idle gaps between items, covers back-to-back results and the holding of outputs between strobes.

// File: rtl/vec_i2f_pkg.sv
// Shared types and decode helpers for the predicated vector integer-to-float converter.
// Assumes the conversion select encoding listed in the block brief.
package vec_i2f_pkg;

    typedef enum logic [1:0] {
        RM_NEAR = 2'b00,
        RM_UP   = 2'b01,
        RM_DOWN = 2'b10,
        RM_ZERO = 2'b11
    } rnd_e;

    typedef enum logic [1:0] {
        FMT_HALF   = 2'd0,
        FMT_SINGLE = 2'd1,
        FMT_DOUBLE = 2'd2
    } fmt_e;

    typedef enum logic [1:0] {
        SRC_16 = 2'd0,
        SRC_32 = 2'd1,
        SRC_64 = 2'd2
    } src_e;

    typedef enum logic [1:0] {
        GRP_16   = 2'd0,
        GRP_32   = 2'd1,
        GRP_64   = 2'd2,
        GRP_NONE = 2'd3
    } grp_e;

    typedef struct packed {
        grp_e grp;
        src_e src;
        fmt_e fmt;
    } conv_cfg_t;

    // Map the 3-bit select onto lane group, source width and result format.
    function automatic conv_cfg_t decode_sel(input logic [2:0] sel);
        conv_cfg_t c;
        case (sel)
            3'd0:    c = '{grp: GRP_16,   src: SRC_16, fmt: FMT_HALF};
            3'd1:    c = '{grp: GRP_32,   src: SRC_32, fmt: FMT_HALF};
            3'd2:    c = '{grp: GRP_32,   src: SRC_32, fmt: FMT_SINGLE};
            3'd3:    c = '{grp: GRP_64,   src: SRC_32, fmt: FMT_DOUBLE};
            3'd4:    c = '{grp: GRP_64,   src: SRC_64, fmt: FMT_HALF};
            3'd5:    c = '{grp: GRP_64,   src: SRC_64, fmt: FMT_SINGLE};
            3'd6:    c = '{grp: GRP_64,   src: SRC_64, fmt: FMT_DOUBLE};
            default: c = '{grp: GRP_NONE, src: SRC_64, fmt: FMT_DOUBLE};
        endcase
        return c;
    endfunction

    // Sign-extend the low 16/32 bits of a lane, or pass all 64 through.
    function automatic logic [63:0] sext_lane(input logic [63:0] raw, input src_e w);
        case (w)
            SRC_16:  return {{48{raw[15]}}, raw[15:0]};
            SRC_32:  return {{32{raw[31]}}, raw[31:0]};
            default: return raw;
        endcase
    endfunction

endpackage

// File: rtl/vec_i2f_lane_cvt.sv
// One lane converter: signed IN_W-bit integer to half/single/double, chosen at run time.
// The packed result is zero-extended or truncated to OUT_W bits.
// Assumes the caller has already sign-extended the integer to IN_W bits. IN_W <= 64.
module vec_i2f_lane_cvt
    import vec_i2f_pkg::*;
#(
    parameter int IN_W  = 64,
    parameter int OUT_W = 64
) (
    input  logic [IN_W-1:0]  int_in,
    input  fmt_e             fmt,
    input  rnd_e             rnd,
    output logic [OUT_W-1:0] fp_out,
    output logic             inexact
);
    localparam int EXT_W = 128;
    localparam int PAD_W = EXT_W - IN_W;

    logic              sgn;
    logic [IN_W-1:0]   mag;
    logic [IN_W-1:0]   norm;
    logic [6:0]        lead;
    logic [EXT_W-1:0]  ext;
    logic [51:0]       frac_t;
    logic              grd;
    logic              stk;
    logic              up;
    logic [52:0]       sum;
    logic              carry;
    logic [7:0]        exp_u;
    logic              ovf_h;
    logic              to_inf;

    // Sign and magnitude of the integer.
    always_comb begin
        sgn = int_in[IN_W-1];
        mag = sgn ? (~int_in + 1'b1) : int_in;
    end

    // Position of the leading one in the magnitude.
    always_comb begin
        lead = '0;
        for (int i = 0; i < IN_W; i++) begin
            if (mag[i]) lead = 7'(i);
        end
    end

    // Left-justify the magnitude in a 128-bit field; bit 127 is the hidden one.
    always_comb begin
        norm = mag << (7'(IN_W - 1) - lead);
        ext  = {norm, {PAD_W{1'b0}}};
    end

    // Cut the fraction, guard and sticky bits for the selected format.
    always_comb begin
        case (fmt)
            FMT_HALF: begin
                frac_t = {42'b0, ext[126:117]};
                grd    = ext[116];
                stk    = |ext[115:0];
            end
            FMT_SINGLE: begin
                frac_t = {29'b0, ext[126:104]};
                grd    = ext[103];
                stk    = |ext[102:0];
            end
            default: begin
                frac_t = ext[126:75];
                grd    = ext[74];
                stk    = |ext[73:0];
            end
        endcase
    end

    // Decide the round increment and apply it; detect a mantissa carry-out.
    always_comb begin
        case (rnd)
            RM_NEAR: up = grd & (stk | frac_t[0]);
            RM_UP:   up = ~sgn & (grd | stk);
            RM_DOWN: up = sgn & (grd | stk);
            default: up = 1'b0;
        endcase
        sum = {1'b0, frac_t} + 53'(up);
        case (fmt)
            FMT_HALF:   carry = sum[10];
            FMT_SINGLE: carry = sum[23];
            default:    carry = sum[52];
        endcase
        exp_u  = {1'b0, lead} + 8'(carry);
        ovf_h  = (exp_u > 8'd15);
        to_inf = (rnd == RM_NEAR) | ((rnd == RM_UP) & ~sgn) | ((rnd == RM_DOWN) & sgn);
    end

    // Pack the result; zero and half-precision overflow are special cases.
    always_comb begin
        inexact = grd | stk | ((fmt == FMT_HALF) & ovf_h);
        if (!ext[127]) begin
            fp_out  = '0;
            inexact = 1'b0;
        end else begin
            case (fmt)
                FMT_HALF: begin
                    if (ovf_h) fp_out = OUT_W'({sgn, (to_inf ? 15'h7c00 : 15'h7bff)});
                    else       fp_out = OUT_W'({sgn, 5'(exp_u + 8'd15), sum[9:0]});
                end
                FMT_SINGLE: fp_out = OUT_W'({sgn, 8'(exp_u + 8'd127), sum[22:0]});
                default:    fp_out = OUT_W'({sgn, 11'({3'b0, exp_u} + 11'd1023), sum[51:0]});
            endcase
        end
    end

endmodule

// File: rtl/vec_i2f_lane_group.sv
// Slices the vector into LANE_W-bit lanes and converts every lane in parallel.
// Also gives the per-bit active mask and the OR of inexact over active lanes.
// Assumes VEC_W is a multiple of LANE_W and that LANE_W is 16, 32 or 64.
module vec_i2f_lane_group
    import vec_i2f_pkg::*;
#(
    parameter int VEC_W  = 128,
    parameter int LANE_W = 64
) (
    input  logic [VEC_W-1:0]   src_vec,
    input  logic [VEC_W/8-1:0] pred,
    input  src_e               src_w,
    input  fmt_e               fmt,
    input  rnd_e               rnd,
    output logic [VEC_W-1:0]   res_vec,
    output logic [VEC_W-1:0]   act_bits,
    output logic               inexact_any
);
    localparam int N_LANES = VEC_W / LANE_W;
    localparam int LANE_B  = LANE_W / 8;

    logic [N_LANES-1:0] lane_ix;

    for (genvar l = 0; l < N_LANES; l++) begin : g_lane
        logic [LANE_W-1:0] sx;
        logic              ix;
        logic              act;

        // Sign-extend the selected source width across the lane.
        always_comb begin
            sx  = LANE_W'(sext_lane(64'(src_vec[l*LANE_W +: LANE_W]), src_w));
            act = pred[l*LANE_B];
        end

        vec_i2f_lane_cvt #(
            .IN_W  (LANE_W),
            .OUT_W (LANE_W)
        ) u_cvt (
            .int_in  (sx),
            .fmt     (fmt),
            .rnd     (rnd),
            .fp_out  (res_vec[l*LANE_W +: LANE_W]),
            .inexact (ix)
        );

        // Spread the lane's predicate over its bits and gate its inexact flag.
        always_comb begin
            act_bits[l*LANE_W +: LANE_W] = {LANE_W{act}};
            lane_ix[l]                   = act & ix;
        end
    end

    // OR the gated inexact flags over all lanes.
    always_comb inexact_any = |lane_ix;

endmodule

// File: rtl/vec_i2f_merge.sv
// Predicated vector integer-to-float converter with merge into the old destination.
// Three lane groups (16/32/64-bit lanes) run in parallel; the select picks one group.
// Active lanes take the converted value and inactive lanes take old_vec.
// The result is registered, so it appears one cycle after in_valid.
// Assumes VEC_W is a multiple of 64.
module vec_i2f_merge
    import vec_i2f_pkg::*;
#(
    parameter int VEC_W = 128
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               in_valid,
    input  logic [VEC_W-1:0]   src_vec,
    input  logic [VEC_W-1:0]   old_vec,
    input  logic [VEC_W/8-1:0] pred,
    input  logic [2:0]         conv_sel,
    input  logic [1:0]         rnd_mode,
    output logic               out_valid,
    output logic [VEC_W-1:0]   out_vec,
    output logic               out_inexact
);
    localparam int N_GRP = 3;

    conv_cfg_t        cfg;
    rnd_e             rnd;
    logic [VEC_W-1:0] g_res [N_GRP];
    logic [VEC_W-1:0] g_act [N_GRP];
    logic             g_ix  [N_GRP];
    logic [VEC_W-1:0] res_sel;
    logic [VEC_W-1:0] act_sel;
    logic             ix_sel;
    logic [VEC_W-1:0] merged;

    // Decode the select and cast the rounding mode.
    always_comb begin
        cfg = decode_sel(conv_sel);
        rnd = rnd_e'(rnd_mode);
    end

    for (genvar g = 0; g < N_GRP; g++) begin : g_grp
        vec_i2f_lane_group #(
            .VEC_W  (VEC_W),
            .LANE_W (16 << g)
        ) u_grp (
            .src_vec     (src_vec),
            .pred        (pred),
            .src_w       (cfg.src),
            .fmt         (cfg.fmt),
            .rnd         (rnd),
            .res_vec     (g_res[g]),
            .act_bits    (g_act[g]),
            .inexact_any (g_ix[g])
        );
    end

    // Pick the lane group for this select; the reserved code activates no lane.
    always_comb begin
        case (cfg.grp)
            GRP_16:  begin res_sel = g_res[0]; act_sel = g_act[0]; ix_sel = g_ix[0]; end
            GRP_32:  begin res_sel = g_res[1]; act_sel = g_act[1]; ix_sel = g_ix[1]; end
            GRP_64:  begin res_sel = g_res[2]; act_sel = g_act[2]; ix_sel = g_ix[2]; end
            default: begin res_sel = '0;       act_sel = '0;       ix_sel = 1'b0;    end
        endcase
        merged = (res_sel & act_sel) | (old_vec & ~act_sel);
    end

    // Output register: load on a strobe, hold otherwise.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            out_valid   <= 1'b0;
            out_vec     <= '0;
            out_inexact <= 1'b0;
        end else begin
            out_valid <= in_valid;
            if (in_valid) begin
                out_vec     <= merged;
                out_inexact <= ix_sel;
            end
        end
    end

endmodule

// File: rtl/vec_i2f_merge_chk.sv
// Property checker for vec_i2f_merge, attached through bind.
// It covers timing, holding, the reserved select, the no-predicate case, zero fill and zero input.
module vec_i2f_merge_chk #(
    parameter int VEC_W = 128
) (
    input logic               clk,
    input logic               rst_n,
    input logic               in_valid,
    input logic [VEC_W-1:0]   src_vec,
    input logic [VEC_W-1:0]   old_vec,
    input logic [VEC_W/8-1:0] pred,
    input logic [2:0]         conv_sel,
    input logic               out_valid,
    input logic [VEC_W-1:0]   out_vec,
    input logic               out_inexact
);
    AST_VALID_FOLLOWS: assert property (@(posedge clk) disable iff (!rst_n)
        in_valid |=> out_valid); // R10
    AST_VALID_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        !in_valid |=> !out_valid); // R10
    AST_HOLD_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        !in_valid |=> ($stable(out_vec) && $stable(out_inexact))); // R10
    AST_RESERVED_PASS: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && conv_sel == 3'd7) |=> (out_vec == $past(old_vec) && !out_inexact)); // R3
    AST_NO_PRED_EXACT: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && pred == '0) |=> (out_vec == $past(old_vec) && !out_inexact)); // R9
    AST_HALF_ZERO_FILL: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && pred[0] && conv_sel == 3'd4) |=> (out_vec[63:16] == '0)); // R5
    AST_ZERO_INPUT: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && pred[0] && conv_sel == 3'd0 && src_vec[15:0] == '0) |=> (out_vec[15:0] == '0)); // R7
endmodule

bind vec_i2f_merge vec_i2f_merge_chk #(.VEC_W(VEC_W)) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .in_valid    (in_valid),
    .src_vec     (src_vec),
    .old_vec     (old_vec),
    .pred        (pred),
    .conv_sel    (conv_sel),
    .out_valid   (out_valid),
    .out_vec     (out_vec),
    .out_inexact (out_inexact)
);

// File: tb/vec_i2f_merge_test.sv
`timescale 1ns/1ps
// Scoreboard bench: the driver pushes model results into a queue and the monitor compares them.
module vec_i2f_merge_test;
    localparam int VW = 128;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          in_valid = 1'b0;
    logic [VW-1:0] src_vec = '0;
    logic [VW-1:0] old_vec = '0;
    logic [VW/8-1:0] pred = '0;
    logic [2:0]    conv_sel = '0;
    logic [1:0]    rnd_mode = '0;
    logic          out_valid;
    logic [VW-1:0] out_vec;
    logic          out_inexact;

    int checks = 0;
    int fails  = 0;
    bit done   = 1'b0;

    logic [VW-1:0] q_vec [$];
    logic          q_ix  [$];
    string         q_tag [$];

    always #2.5 clk = ~clk;

    vec_i2f_merge #(.VEC_W(VW)) uut (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .src_vec(src_vec),
        .old_vec(old_vec), .pred(pred), .conv_sel(conv_sel), .rnd_mode(rnd_mode),
        .out_valid(out_valid), .out_vec(out_vec), .out_inexact(out_inexact)
    );

    // Reference conversion: a remainder-versus-half rounding model. Returns {inexact, bits}.
    function automatic logic [64:0] ref_cvt(input logic [63:0] sx, input int fmt, input logic [1:0] rm);
        logic sg, ix, up, toinf;
        logic [63:0] mag, q, rem, half, res;
        int msb, m, bias, ew, sh;
        sg  = sx[63];
        mag = sg ? (~sx + 64'd1) : sx;
        if (mag == 64'd0) return 65'd0;
        msb = 0;
        for (int i = 0; i < 64; i++) if (mag[i]) msb = i;
        m    = (fmt == 0) ? 10 : (fmt == 1) ? 23 : 52;
        bias = (fmt == 0) ? 15 : (fmt == 1) ? 127 : 1023;
        ew   = (fmt == 0) ? 5 : (fmt == 1) ? 8 : 11;
        ix = 1'b0;
        if (msb <= m) q = mag << (m - msb);
        else begin
            sh   = msb - m;
            q    = mag >> sh;
            rem  = mag & ((64'd1 << sh) - 64'd1);
            half = 64'd1 << (sh - 1);
            ix   = (rem != 64'd0);
            case (rm)
                2'b00:   up = (rem > half) || ((rem == half) && q[0]);
                2'b01:   up = !sg && ix;
                2'b10:   up = sg && ix;
                default: up = 1'b0;
            endcase
            q = q + 64'(up);
            if (q == (64'd1 << (m + 1))) begin q = q >> 1; msb++; end
        end
        if (fmt == 0 && msb > 15) begin
            toinf = (rm == 2'b00) || (rm == 2'b01 && !sg) || (rm == 2'b10 && sg);
            res = {48'd0, sg, (toinf ? 15'h7c00 : 15'h7bff)};
            ix  = 1'b1;
        end else begin
            res = (64'(sg) << (ew + m)) | (64'(msb + bias) << m) | (q & ((64'd1 << m) - 64'd1));
        end
        return {ix, res};
    endfunction

    // Whole-vector expected result, built from the requirements.
    task automatic exp_calc(input logic [VW-1:0] s, input logic [VW-1:0] o, input logic [VW/8-1:0] p,
                            input logic [2:0] sel, input logic [1:0] rm,
                            output logic [VW-1:0] v, output logic ix);
        int lw, sw, fmt;
        logic [63:0] raw, sx, msk;
        logic [64:0] r;
        v = o; ix = 1'b0;
        case (sel)
            3'd0: begin lw = 16; sw = 16; fmt = 0; end
            3'd1: begin lw = 32; sw = 32; fmt = 0; end
            3'd2: begin lw = 32; sw = 32; fmt = 1; end
            3'd3: begin lw = 64; sw = 32; fmt = 2; end
            3'd4: begin lw = 64; sw = 64; fmt = 0; end
            3'd5: begin lw = 64; sw = 64; fmt = 1; end
            3'd6: begin lw = 64; sw = 64; fmt = 2; end
            default: return;
        endcase
        for (int l = 0; l < VW / lw; l++) begin
            if (p[l * lw / 8]) begin
                raw = 64'(s >> (l * lw));
                msk = (sw == 64) ? '1 : ((64'd1 << sw) - 64'd1);
                sx  = raw[sw - 1] ? (raw | ~msk) : (raw & msk);
                r   = ref_cvt(sx, fmt, rm);
                for (int b = 0; b < lw; b++) v[l * lw + b] = r[b];
                ix = ix | r[64];
            end
        end
    endtask

    // Driver: apply one item for one cycle and push its expected result.
    task automatic send(input logic [VW-1:0] s, input logic [VW-1:0] o, input logic [VW/8-1:0] p,
                        input logic [2:0] sel, input logic [1:0] rm, input string tag);
        logic [VW-1:0] ev;
        logic eix;
        @(posedge clk); #1;
        src_vec = s; old_vec = o; pred = p; conv_sel = sel; rnd_mode = rm; in_valid = 1'b1;
        exp_calc(s, o, p, sel, rm, ev, eix);
        q_vec.push_back(ev); q_ix.push_back(eix); q_tag.push_back(tag);
    endtask

    // Idle cycles; the inputs change to junk to show they are ignored (R10).
    task automatic idle(input int n);
        for (int i = 0; i < n; i++) begin
            @(posedge clk); #1;
            in_valid = 1'b0;
            src_vec  = {$urandom, $urandom, $urandom, $urandom};
            old_vec  = {$urandom, $urandom, $urandom, $urandom};
        end
    endtask

    // Monitor: compare each result, and check that outputs hold between results.
    logic [VW-1:0] last_v = '0;
    logic          last_ix = 1'b0;
    initial begin
        forever begin
            @(negedge clk);
            if (rst_n && !done) begin
                if (out_valid) begin
                    checks++;
                    if (q_vec.size() == 0) begin
                        fails++;
                        $display("FAIL R10 unexpected out_valid: actual 1 expected 0");
                    end else begin
                        logic [VW-1:0] ev;
                        logic eix;
                        string t;
                        ev = q_vec.pop_front(); eix = q_ix.pop_front(); t = q_tag.pop_front();
                        if (out_vec !== ev || out_inexact !== eix) begin
                            fails++;
                            $display("FAIL %s: actual %h/%b expected %h/%b", t, out_vec, out_inexact, ev, eix);
                        end
                        last_v = ev; last_ix = eix;
                    end
                end else begin
                    checks++;
                    if (out_vec !== last_v || out_inexact !== last_ix) begin
                        fails++;
                        $display("FAIL R10 hold: actual %h/%b expected %h/%b", out_vec, out_inexact, last_v, last_ix);
                    end
                end
            end
        end
    end

    // Watchdog: a hung run counts as a failure.
    initial begin
        repeat (50000) @(posedge clk);
        if (!done) begin
            fails++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    end

    localparam logic [VW-1:0] OLD_PAT = 128'hA5A5_5A5A_C3C3_3C3C_0F0F_F0F0_1234_5678;

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk);
        checks++;
        if (out_valid !== 1'b0 || out_vec !== '0 || out_inexact !== 1'b0) begin
            fails++;
            $display("FAIL R11 reset state: actual %b/%h/%b expected 0/0/0", out_valid, out_vec, out_inexact);
        end
        @(posedge clk); #1; rst_n = 1'b1;

        // R1 R7: 16-bit lanes to half, exact and rounded values
        send({16'd3, 16'd2049, 16'h7fff, 16'h8000, 16'd1000, 16'hffff, 16'd1, 16'd0}, OLD_PAT, '1, 3'd0, 2'b00, "R1 R7 i16 to half");
        // R6: rounding modes on 32-bit to single, ties and near-ties
        for (int rm = 0; rm < 4; rm++)
            send({32'h7fffffff, 32'd16777219, -32'sd16777217, 32'd16777217}, OLD_PAT, '1, 3'd2, 2'(rm), "R6 i32 to single modes");
        // R1: 64-bit extremes to double
        send({64'h7fffffffffffffff, 64'h8000000000000000}, OLD_PAT, '1, 3'd6, 2'b00, "R1 i64 to double near");
        send({64'h7fffffffffffffff, 64'h8000000000000000}, OLD_PAT, '1, 3'd6, 2'b11, "R1 i64 to double zero");
        // R4: 32-bit source in 64-bit lanes with junk upper bits
        send({64'h12345678_00000400, 64'hdeadbeef_ffffff85}, OLD_PAT, '1, 3'd3, 2'b00, "R4 i32 to double junk upper");
        send({32'hffff0000, 32'h0000fffb, 32'h12340064, 32'hcafe0000}, OLD_PAT, '1, 3'd0, 2'b00, "R4 i16 in narrow lanes");
        // R5: narrow results zero-filled
        send({32'd0, -32'sd5, 32'd100, 32'd70000}, OLD_PAT, '1, 3'd1, 2'b00, "R5 i32 to half fill");
        send({64'h0000000100000001, -64'sd3}, OLD_PAT, '1, 3'd5, 2'b01, "R5 i64 to single fill");
        // R8: half overflow, both signs, every mode
        for (int rm = 0; rm < 4; rm++)
            send({64'sd1 <<< 40, -(64'sd1 <<< 20)}, OLD_PAT, '1, 3'd4, 2'(rm), "R8 half overflow");
        // R2: only non-leading predicate bits set, then leading bits of lanes 0 and 2
        send({32'd7, 32'd8, 32'd9, 32'd10}, OLD_PAT, 16'heeee, 3'd2, 2'b00, "R2 non-leading pred bits");
        send({32'd7, 32'd8, 32'd9, 32'd10}, OLD_PAT, 16'h0101, 3'd2, 2'b00, "R2 leading pred bits");
        // R3: reserved select leaves old vector
        send({32'd16777217, 32'd1, 32'd2, 32'd3}, OLD_PAT, '1, 3'd7, 2'b00, "R3 reserved select");
        // R9: only the inexact lane is inactive
        send({32'd5, 32'd6, 32'd7, 32'd16777217}, OLD_PAT, 16'hfff0, 3'd2, 2'b00, "R9 inactive inexact lane");
        idle(3);

        // R10 and general coverage: random items with idle gaps
        for (int k = 0; k < 300; k++) begin
            logic [VW-1:0] s;
            s = {$urandom, $urandom, $urandom, $urandom};
            if ($urandom % 2) s = s >> ($urandom % 120);
            send(s, {$urandom, $urandom, $urandom, $urandom}, 16'($urandom), 3'($urandom), 2'($urandom), "R10 random item");
            if ($urandom % 4 == 0) idle(1 + $urandom % 3);
        end
        idle(4);
        wait (q_vec.size() == 0);
        @(negedge clk);
        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

endmodule